// File: doc/BRIEF.md
# Eight-Channel Analog Output Update Controller

This block sits between a byte-wide host register port and eight 12-bit digital-to-analog converters. The host writes each channel's code as two bytes. The block collects them in per-channel holding registers and moves them to per-channel output registers. A move happens either for one channel at a time (automatic mode) or for all channels together (simultaneous mode). The all-channel move is started by a host read at a command offset or by the rising edge of an external timer strobe.

Host reads at certain offsets are commands and carry no data. One read moves all channels and enters simultaneous mode. Another moves all channels and goes back to automatic mode. A third clears the interrupt flag. Two more switch an output restriction on or off. While the restriction is on, each output code is clamped so that it stays near the zero point of its channel's range. Each channel's range (unipolar straight binary, or bipolar offset binary) is given by a static input. The restriction is active after reset, so nothing downstream sees a large step before software sets up the channels.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset all output registers and holding registers are zero, the block is in automatic mode, the restriction is on and the interrupt flag is low.
- R2: Channel n owns byte offsets 2n and 2n+1. A write to 2n loads code bits 7..0. A write to 2n+1 loads code bits 11..8 from data bits 3..0, and data bits 7..4 are ignored.
- R3: In automatic mode, a write to a channel's high byte sets that channel's output to the assembled 12-bit value at the next clock edge. A low-byte write alone leaves every output unchanged.
- R4: A read of offset 0x8 copies all eight holding registers to the outputs at the next edge and enters simultaneous mode.
- R5: A read of offset 0xA copies all eight holding registers to the outputs at the next edge and returns to automatic mode.
- R6: In simultaneous mode, writes of either byte change only holding registers. The outputs keep their values until an all-channel move.
- R7: A rising edge of the timer strobe copies all holding registers to the outputs and does not change the mode. A strobe that stays high causes no further moves.
- R8: A strobe rising edge sets the interrupt flag when irq_en is high and leaves it alone when irq_en is low. A read of offset 0xC clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R9: A read of offset 0xE turns the restriction on and a read of offset 0xF turns it off. restrict_on shows the current state.
- R10: While the restriction is on, a unipolar channel outputs min(code, 614). A bipolar channel (midpoint 0x800) outputs its code clamped to 1434..2662. When the restriction is off, the output is the stored code unchanged, and turning the restriction off shows the stored value again.
- R11: bus_rdata is always 0x00. Reads at offsets other than 0x8, 0xA, 0xC, 0xE and 0xF have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per command |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, always zero |
| timer_strobe | input | 1 | External update strobe, acts on its rising edge |
| irq_en | input | 1 | Lets strobe edges raise the interrupt flag |
| chan_bipolar | input | 8 | Per-channel range kind: 1 = bipolar offset binary, 0 = unipolar |
| dac_codes | output | 96 | Eight 12-bit output codes, channel n in bits 12n+11..12n |
| restrict_on | output | 1 | Restriction active |
| irq | output | 1 | Interrupt request flag |

## Verification
The assertions check the following on every cycle. Outputs change only on an all-channel move or on an automatic-mode high-byte write. A move copies the holding registers. The mode, restriction and interrupt flag follow their command reads. A unipolar restricted output never exceeds the limit. Only the bench's scenarios can show that the byte lanes land on the correct channel and that the upper nibble is ignored. They also show the exact clamp values near both edges of the bipolar window, that a held-high strobe does not repeat, and that a set wins over a clear in the same cycle. The bench sweeps codes across the full 12-bit range on all eight channels and compares against a model written from the requirements.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int NCH_DEF      = 8;
  localparam int DW_DEF       = 12;
  localparam int PCT_DEF      = 15;

  // command offsets (behavioural: host software depends on them)
  localparam int OFS_SIM_UPD  = 8;
  localparam int OFS_AUTO_UPD = 10;
  localparam int OFS_IRQ_CLR  = 12;
  localparam int OFS_RSTR_ON  = 14;
  localparam int OFS_RSTR_OFF = 15;

  // limit in codes for a restricted output, as an offset from the zero point
  function automatic int restrict_limit(input int dw, input int pct);
    return ((1 << dw) * pct) / 100;
  endfunction

  // clamp a code so that it stays within limit of the range zero point
  function automatic int restricted_code(input int code, input bit bipolar,
                                         input int dw, input int pct);
    int zero, lo, hi;
    zero = bipolar ? (1 << (dw - 1)) : 0;
    lo   = bipolar ? zero - restrict_limit(dw, pct) : 0;
    hi   = zero + restrict_limit(dw, pct);
    if (code > hi) return hi;
    if (code < lo) return lo;
    return code;
  endfunction
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
  parameter int NCH = 8,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  output logic [NCH-1:0] lo_wr,
  output logic [NCH-1:0] hi_wr,
  output logic           cmd_sim,
  output logic           cmd_auto,
  output logic           cmd_irqclr,
  output logic           cmd_ron,
  output logic           cmd_roff
);
  import dac_upd_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lo_wr[g] = bus_wr && (bus_addr == AW'(2 * g));
    assign hi_wr[g] = bus_wr && (bus_addr == AW'(2 * g + 1));
  end

  assign cmd_sim    = bus_rd && (bus_addr == AW'(OFS_SIM_UPD));
  assign cmd_auto   = bus_rd && (bus_addr == AW'(OFS_AUTO_UPD));
  assign cmd_irqclr = bus_rd && (bus_addr == AW'(OFS_IRQ_CLR));
  assign cmd_ron    = bus_rd && (bus_addr == AW'(OFS_RSTR_ON));
  assign cmd_roff   = bus_rd && (bus_addr == AW'(OFS_RSTR_OFF));

  // R2: at most one byte lane is written per cycle
  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_wr, hi_wr}));
  // R11: commands arise only from reads
  a_r11_cmd_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> !(cmd_sim || cmd_auto || cmd_irqclr || cmd_ron || cmd_roff));
endmodule

// File: rtl/dac_mode_ctrl.sv
module dac_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_sim,
  input  logic cmd_auto,
  input  logic cmd_irqclr,
  input  logic cmd_ron,
  input  logic cmd_roff,
  input  logic timer_strobe,
  input  logic irq_en,
  output logic sim_mode,
  output logic restrict_on,
  output logic irq,
  output logic upd_all
);
  logic strobe_q;
  logic tmr_rise;

  assign tmr_rise = timer_strobe && !strobe_q;
  assign upd_all  = cmd_sim || cmd_auto || tmr_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q    <= 1'b0;
      sim_mode    <= 1'b0;
      restrict_on <= 1'b1;
      irq         <= 1'b0;
    end else begin
      strobe_q <= timer_strobe;
      if (cmd_sim)       sim_mode <= 1'b1;
      else if (cmd_auto) sim_mode <= 1'b0;
      if (cmd_ron)       restrict_on <= 1'b1;
      else if (cmd_roff) restrict_on <= 1'b0;
      if (tmr_rise && irq_en) irq <= 1'b1;
      else if (cmd_irqclr)    irq <= 1'b0;
    end
  end

  a_r4_enter_sim: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sim |=> sim_mode);
  a_r5_leave_sim: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_auto |=> !sim_mode);
  a_r7_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_sim && !cmd_auto) |=> $stable(sim_mode));
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rise && irq_en) |=> irq);
  a_r8_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_irqclr && !(tmr_rise && irq_en)) |=> !irq);
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_irqclr && !tmr_rise) |=> $stable(irq));
  a_r9_rstr_on: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ron |=> restrict_on);
  a_r9_rstr_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_roff |=> !restrict_on);
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DW  = 12,
  parameter int PCT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [7:0]    wdata,
  input  logic          sim_mode,
  input  logic          upd_all,
  input  logic          bipolar,
  input  logic          restrict_on,
  output logic [DW-1:0] code_out
);
  import dac_upd_pkg::*;
  localparam int HB = DW - 8;

  logic [DW-1:0] hold_q;
  logic [DW-1:0] out_q;
  logic [DW-1:0] assembled;
  logic          auto_load;

  assign assembled = {wdata[HB-1:0], hold_q[7:0]};
  assign auto_load = hi_wr && !sim_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (lo_wr) hold_q[7:0]    <= wdata;
      if (hi_wr) hold_q[DW-1:8] <= wdata[HB-1:0];
      if (upd_all)        out_q <= hold_q;
      else if (auto_load) out_q <= assembled;
    end
  end

  always_comb begin
    if (restrict_on)
      code_out = DW'(restricted_code(int'(out_q), bipolar, DW, PCT));
    else
      code_out = out_q;
  end

  a_r3_auto_load: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_load && !upd_all) |=> out_q[7:0] == $past(hold_q[7:0]));
  a_r4_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    upd_all |=> out_q == $past(hold_q));
  a_r6_out_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_all && !auto_load) |=> $stable(out_q));
  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !restrict_on |-> code_out == out_q);
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int NCH = dac_upd_pkg::NCH_DEF,
  parameter int DW  = dac_upd_pkg::DW_DEF,
  parameter int PCT = dac_upd_pkg::PCT_DEF,
  localparam int AW = $clog2(2 * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              timer_strobe,
  input  logic              irq_en,
  input  logic [NCH-1:0]    chan_bipolar,
  output logic [NCH*DW-1:0] dac_codes,
  output logic              restrict_on,
  output logic              irq
);
  import dac_upd_pkg::*;
  localparam int LIMIT = restrict_limit(DW, PCT);

  logic [NCH-1:0] lo_wr, hi_wr;
  logic cmd_sim, cmd_auto, cmd_irqclr, cmd_ron, cmd_roff;
  logic sim_mode, upd_all;

  assign bus_rdata = '0;

  dac_bus_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .lo_wr(lo_wr), .hi_wr(hi_wr), .cmd_sim(cmd_sim),
    .cmd_auto(cmd_auto), .cmd_irqclr(cmd_irqclr), .cmd_ron(cmd_ron),
    .cmd_roff(cmd_roff)
  );

  dac_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_sim(cmd_sim), .cmd_auto(cmd_auto),
    .cmd_irqclr(cmd_irqclr), .cmd_ron(cmd_ron), .cmd_roff(cmd_roff),
    .timer_strobe(timer_strobe), .irq_en(irq_en), .sim_mode(sim_mode),
    .restrict_on(restrict_on), .irq(irq), .upd_all(upd_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_channel #(.DW(DW), .PCT(PCT)) u_ch (
      .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr[c]), .hi_wr(hi_wr[c]),
      .wdata(bus_wdata), .sim_mode(sim_mode), .upd_all(upd_all),
      .bipolar(chan_bipolar[c]), .restrict_on(restrict_on),
      .code_out(dac_codes[c*DW +: DW])
    );

    a_r10_uni_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (restrict_on && !chan_bipolar[c]) |-> int'(dac_codes[c*DW +: DW]) <= LIMIT);
  end

  a_r11_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_rdata == 8'h00);
endmodule

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic timer_strobe = 1'b0, irq_en = 1'b0;
  logic [NCH-1:0] chan_bipolar = 8'b1010_1010;
  logic [NCH*DW-1:0] dac_codes;
  logic restrict_on, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model
  int  m_hold [NCH];
  int  m_out  [NCH];
  bit  m_sim, m_rstr, m_irq;

  always #10 clk = ~clk;

  dac_update_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_strobe(timer_strobe), .irq_en(irq_en), .chan_bipolar(chan_bipolar),
    .dac_codes(dac_codes), .restrict_on(restrict_on), .irq(irq)
  );

  function automatic int expect_code(int ch);
    int v, dev;
    v = m_out[ch];
    if (!m_rstr) return v;
    if (!chan_bipolar[ch]) return (v > 614) ? 614 : v;
    dev = v - 2048;
    if (dev > 614)  return 2662;
    if (dev < -614) return 1434;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int ch = 0; ch < NCH; ch++)
      chk(req, int'(dac_codes[ch*DW +: DW]), expect_code(ch));
    chk(req, int'(restrict_on), int'(m_rstr));
    chk(req, int'(irq), int'(m_irq));
  endtask

  task automatic m_xfer();
    for (int ch = 0; ch < NCH; ch++) m_out[ch] = m_hold[ch];
  endtask

  task automatic wr(int addr, int data);
    int ch;
    ch = addr / 2;
    @(negedge clk);
    bus_addr = 4'(addr); bus_wdata = 8'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (addr % 2 == 0) m_hold[ch] = (m_hold[ch] & 32'hF00) | (data & 8'hFF);
    else begin
      m_hold[ch] = (m_hold[ch] & 32'h0FF) | ((data & 4'hF) << 8);
      if (!m_sim) m_out[ch] = m_hold[ch];
    end
  endtask

  task automatic rd(int addr);
    @(negedge clk);
    bus_addr = 4'(addr); bus_rd = 1'b1;
    #1 chk("R11 rdata", int'(bus_rdata), 0);
    @(negedge clk);
    bus_rd = 1'b0;
    case (addr)
      8:  begin m_xfer(); m_sim = 1; end
      10: begin m_xfer(); m_sim = 0; end
      12: m_irq = 0;
      14: m_rstr = 1;
      15: m_rstr = 0;
      default: ;
    endcase
  endtask

  task automatic strobe_rise();
    @(negedge clk);
    timer_strobe = 1'b1;
    @(negedge clk);
    m_xfer();
    if (irq_en) m_irq = 1;
  endtask

  task automatic put(int ch, int v, int junk);
    wr(2 * ch, v & 8'hFF);
    wr(2 * ch + 1, ((v >> 8) & 4'hF) | (junk << 4));
  endtask

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin m_hold[ch] = 0; m_out[ch] = 0; end
    m_sim = 0; m_rstr = 1; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    // R10: restricted sweep over the code range in automatic mode (R3, R2)
    for (int v = 0; v < 4096; v += 61) begin
      for (int ch = 0; ch < NCH; ch++) begin
        put(ch, (v + 7 * ch) % 4096, (v / 61) % 16);
        chk_all("R10 restricted sweep");
      end
    end
    foreach (m_hold[i]) ;
    begin
      int edges [8] = '{613, 614, 615, 1433, 1434, 2662, 2663, 4095};
      for (int e = 0; e < 8; e++) begin
        for (int ch = 0; ch < NCH; ch++) put(ch, edges[e], 4'hF);
        chk_all("R10 clamp edges");
      end
    end

    // R9: restriction off shows stored codes
    rd(15);
    chk_all("R9 restrict off");
    chk("R9 flag", int'(restrict_on), 0);

    // R2: upper nibble of high byte ignored, lanes correct
    for (int ch = 0; ch < NCH; ch++) begin
      put(ch, 256 * ch + 17 * ch + 3, 4'hA);
      chk_all("R2 lanes");
    end

    // R3: low-byte write alone leaves outputs
    for (int ch = 0; ch < NCH; ch++) begin
      wr(2 * ch, 8'h5C);
      chk_all("R3 low only");
    end

    // R4 / R6: simultaneous mode
    rd(8);
    chk_all("R4 sim update");
    for (int ch = 0; ch < NCH; ch++) begin
      put(ch, 4095 - 300 * ch, 4'h3);
      chk_all("R6 held in sim");
    end
    for (int a = 0; a < 8; a++) begin
      rd(a);
      chk_all("R11 no-op read");
    end
    rd(9); chk_all("R11 no-op read 9");
    rd(11); chk_all("R11 no-op read 11");
    rd(13); chk_all("R11 no-op read 13");

    // R5: back to automatic
    rd(10);
    chk_all("R5 auto update");
    put(3, 1234, 4'h0);
    chk_all("R5 auto after");

    // R4 second pass
    rd(8);
    for (int ch = 0; ch < NCH; ch++) wr(2 * ch + 1, ch);
    chk_all("R6 high only sim");
    rd(8);
    chk_all("R4 repeat");

    // R7 / R8: strobe
    irq_en = 1'b1;
    for (int ch = 0; ch < NCH; ch++) put(ch, 500 * ch + 11, 4'h9);
    strobe_rise();
    chk_all("R7 strobe xfer");
    chk("R8 irq set", int'(irq), 1);
    for (int ch = 0; ch < NCH; ch++) put(ch, 3000 - 200 * ch, 4'h1);
    repeat (3) @(negedge clk);
    chk_all("R7 held high no repeat");
    timer_strobe = 1'b0;
    @(negedge clk);
    rd(12);
    chk_all("R8 irq clear");
    strobe_rise();
    chk_all("R7 second rise");
    chk("R7 mode kept sim", int'(m_sim), 1);
    timer_strobe = 1'b0;
    put(0, 77, 0);
    chk_all("R7 mode kept");
    irq_en = 1'b0;
    rd(12);
    @(negedge clk);
    strobe_rise();
    chk_all("R8 irq_en low");
    timer_strobe = 1'b0;
    // set wins over clear
    irq_en = 1'b1;
    put(1, 999, 0);
    @(negedge clk);
    timer_strobe = 1'b1; bus_rd = 1'b1; bus_addr = 4'hC;
    @(negedge clk);
    bus_rd = 1'b0;
    m_xfer(); m_irq = 0; m_irq = 1;
    chk_all("R8 set wins");
    timer_strobe = 1'b0;

    // R9: restriction back on
    rd(10);
    rd(14);
    chk_all("R9 restrict on");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule